// File: doc/BRIEF.md
# Gated Transfer Interval Timer

This block times how long an active-low gate line stays asserted. One system drives the gate low just before it starts a data transfer and high again just after the transfer ends. After an arm pulse the timer zeroes its count and waits for the gate's falling edge. It then advances the count once every fixed quantum of clock cycles until the gate rises again, and raises a done flag with the final count.

The count is kept as byte-wide lanes that carry into one another. If the top lane wraps past its maximum, the timer raises an error flag instead of reporting a result. Both flags, and the count, hold until the next arm pulse.

The controller is a five-state machine:
- `XS_IDLE`: after reset.
- `XS_WAIT_FALL`: armed, waiting for the start edge.
- `XS_COUNTING`: measuring.
- `XS_DONE`: a valid result is held.
- `XS_ERROR`: the interval was too long.

Its transitions are:
- IDLE→WAIT_FALL on arm.
- WAIT_FALL→COUNTING on a synchronized falling edge.
- COUNTING→DONE on a synchronized rising edge.
- COUNTING→ERROR on a count wrap. A wrap takes priority over a rising edge in the same cycle.
- DONE→WAIT_FALL and ERROR→WAIT_FALL on arm.

Top module: `xfer_interval_timer`

## Requirements
- R1: The measurement starts on the synchronized high-to-low gate edge seen in WAIT_FALL and ends on the next low-to-high edge. For a gate held low for L clock cycles, the reported count is floor(L/16).
- R2: An arm pulse in IDLE, DONE or ERROR clears the count to zero and drops both flags from the next cycle. The block then waits for the start edge.
- R3: The count advances by exactly one, once per 16-clock quantum, and never sooner than 16 cycles after its previous change. The quantum timer restarts at the start edge, so L=15 gives 0 and L=16 gives 1.
- R4: The count is built from LANES lanes of LANE_W bits. Lane k sits at bits [k*LANE_W +: LANE_W] and has weight 2^(k*LANE_W), which gives weights 1, 256 and 65536 by default. A lane that passes its maximum carries into the next lane.
- R5: After a normal end, done_o stays 1 and count_o stays unchanged until the next arm pulse.
- R6: A step taken when every lane is at its maximum raises err_o instead of done_o, with count_o reading zero. With W = LANES*LANE_W, L = 16*2^W-1 reports done with the all-ones count, and L = 16*2^W reports an error. err_o stays set, and a later gate rise is ignored, until the next arm pulse. done_o and err_o are never both 1.
- R7: An arm pulse during a measurement is ignored. In WAIT_FALL, a rising gate edge is ignored.
- R8: The gate passes two synchronizer flops before edge detection. done_o rises on the third rising clock edge after the gate input goes high.
- R9: After reset, count_o is 0 and done_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle arm request |
| gate_n_i | input | 1 | Asynchronous active-low transfer gate |
| count_o | output | LANES*LANE_W (24) | Interval count in quanta |
| done_o | output | 1 | Valid result held |
| err_o | output | 1 | Interval too long |

## Verification
The bound checker enforces several rules on every cycle:
- the flags are never both set;
- each count change is a unit step or a wrap to zero, spaced at least one quantum apart;
- a held result or error stays put until arm;
- an arm from a finished state empties the count and the flags.

The scenarios carry the rest: the floor(L/16) mapping across the quantum boundary and across a lane carry, the exact overflow boundary on either side, the three-edge synchronizer latency, and the ignored arm and rising edges. The bench instance uses 3-bit lanes so that overflow is reachable.

// File: rtl/xit_pkg.sv
package xit_pkg;
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_WAIT_FALL,
        XS_COUNTING,
        XS_DONE,
        XS_ERROR
    } xit_state_e;
endpackage

// File: rtl/xit_gate_sync.sv
// Synchronizes the asynchronous gate and flags its edges.
module xit_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_n_i,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], gate_n_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign fall_o = last_q & ~chain_q[STAGES-1];
    assign rise_o = ~last_q & chain_q[STAGES-1];
endmodule

// File: rtl/xit_prescaler.sv
// Divides the clock into fixed quanta of 2**QUANT_LOG2 cycles.
module xit_prescaler #(
    parameter int QUANT_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    logic [QUANT_LOG2-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (restart_i)
            div_q <= '0;
        else if (run_i)
            div_q <= div_q + 1'b1;
    end

    assign tick_o = run_i & (div_q == '1);
endmodule

// File: rtl/xit_lane_counter.sv
// Counter made of byte-style lanes joined by a carry chain.
module xit_lane_counter #(
    parameter int LANE_W = 8,
    parameter int LANES  = 3,
    localparam int CW    = LANE_W * LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    output logic [CW-1:0] count_o,
    output logic          wrap_o
);
    logic [LANES:0] carry;
    assign carry[0] = inc_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (clear_i)
                lane_q <= '0;
            else if (carry[g])
                lane_q <= lane_q + 1'b1;
        end

        assign carry[g+1] = carry[g] & (lane_q == '1);
        assign count_o[g*LANE_W +: LANE_W] = lane_q;
    end

    assign wrap_o = carry[LANES];
endmodule

// File: rtl/xfer_interval_timer.sv
module xfer_interval_timer
    import xit_pkg::*;
#(
    parameter int LANE_W      = 8,
    parameter int LANES       = 3,
    parameter int QUANT_LOG2  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = LANE_W * LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          gate_n_i,
    output logic [CW-1:0] count_o,
    output logic          done_o,
    output logic          err_o
);
    xit_state_e state_q, state_d;
    logic fall, rise, tick, wrap;
    logic clear_cnt, restart_div, run_div, inc_cnt;

    xit_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_n_i (gate_n_i),
        .fall_o   (fall),
        .rise_o   (rise)
    );

    xit_prescaler #(.QUANT_LOG2(QUANT_LOG2)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_div),
        .run_i     (run_div),
        .tick_o    (tick)
    );

    xit_lane_counter #(.LANE_W(LANE_W), .LANES(LANES)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_cnt),
        .inc_i   (inc_cnt),
        .count_o (count_o),
        .wrap_o  (wrap)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= XS_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:      if (arm_i) state_d = XS_WAIT_FALL;
            XS_WAIT_FALL: if (fall)  state_d = XS_COUNTING;
            XS_COUNTING: begin
                if (wrap)      state_d = XS_ERROR;
                else if (rise) state_d = XS_DONE;
            end
            XS_DONE:      if (arm_i) state_d = XS_WAIT_FALL;
            XS_ERROR:     if (arm_i) state_d = XS_WAIT_FALL;
            default:      state_d = XS_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        clear_cnt   = 1'b0;
        restart_div = 1'b0;
        run_div     = 1'b0;
        done_o      = 1'b0;
        err_o       = 1'b0;
        unique case (state_q)
            XS_IDLE:      clear_cnt   = arm_i;
            XS_WAIT_FALL: restart_div = fall;
            XS_COUNTING:  run_div     = 1'b1;
            XS_DONE: begin
                done_o    = 1'b1;
                clear_cnt = arm_i;
            end
            XS_ERROR: begin
                err_o     = 1'b1;
                clear_cnt = arm_i;
            end
            default: ;
        endcase
    end

    assign inc_cnt = tick;
endmodule

// File: rtl/xit_checker.sv
module xit_checker #(
    parameter int CW         = 24,
    parameter int QUANT_LOG2 = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_i,
    input logic [CW-1:0] count_o,
    input logic          done_o,
    input logic          err_o
);
    localparam int QUANT = 1 << QUANT_LOG2;

    logic [CW-1:0]       prev_q;
    logic [QUANT_LOG2:0] gap_q;
    logic                changed;

    assign changed = (count_o != prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            gap_q  <= '0;
        end else begin
            prev_q <= count_o;
            if (changed)
                gap_q <= 1;
            else if (gap_q != '1)
                gap_q <= gap_q + 1'b1;
        end
    end

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !arm_i |=> done_o && $stable(count_o));

    a_r6_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !arm_i |=> err_o && $stable(count_o));

    a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && (done_o || err_o) |=> count_o == '0 && !done_o && !err_o);

    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> (count_o == prev_q + CW'(1)) || (count_o == '0));

    a_r3_quantum_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        changed && count_o != '0 |-> gap_q >= (QUANT_LOG2+1)'(QUANT));
endmodule

bind xfer_interval_timer xit_checker #(.CW(CW), .QUANT_LOG2(QUANT_LOG2)) u_xit_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm_i),
    .count_o (count_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/test_xfer_interval_timer.sv
module test_xfer_interval_timer;
    localparam int LW = 3;
    localparam int NL = 3;
    localparam int W  = LW * NL;
    localparam int FULL = 16 * (1 << W);

    typedef struct {
        logic         done;
        logic         err;
        logic [W-1:0] count;
        string        req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_i = 1'b0;
    logic gate_n_i = 1'b1;
    logic [W-1:0] count_o;
    logic done_o, err_o;

    int checks = 0;
    int fails  = 0;
    exp_t sb_q[$];
    bit reported = 1'b0;

    always #5 clk = ~clk;

    xfer_interval_timer #(.LANE_W(LW), .LANES(NL)) i_xfer_interval_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_i),
        .gate_n_i (gate_n_i),
        .count_o  (count_o),
        .done_o   (done_o),
        .err_o    (err_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each reported result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !reported && (done_o || err_o)) begin
            reported = 1'b1;
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL unexpected result: actual done=%0b err=%0b count=%0h expected none",
                         done_o, err_o, count_o);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.req, " done"},  32'(done_o),  32'(e.done));
                chk({e.req, " err"},   32'(err_o),   32'(e.err));
                chk({e.req, " count"}, 32'(count_o), 32'(e.count));
            end
        end else if (!done_o && !err_o) begin
            reported = 1'b0;
        end
    end

    task automatic arm_pulse(string req);
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        chk({req, " count cleared"}, 32'(count_o), 0);
        chk({req, " flags cleared"}, {30'b0, done_o, err_o}, 0);
    endtask

    // Driver: gate low for len cycles, optional arm pulse at index arm_at
    task automatic measure(int len, int arm_at, string req);
        exp_t e;
        e.req = req;
        if (len >= FULL) begin
            e.done = 1'b0; e.err = 1'b1; e.count = '0;
        end else begin
            e.done = 1'b1; e.err = 1'b0; e.count = W'(len / 16);
        end
        sb_q.push_back(e);
        repeat (3) @(negedge clk);
        gate_n_i = 1'b0;
        for (int i = 0; i < len; i++) begin
            arm_i = (i == arm_at);
            @(negedge clk);
        end
        arm_i = 1'b0;
        gate_n_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 count", 32'(count_o), 0);
        chk("R9 flags", {30'b0, done_o, err_o}, 0);

        // R1 basic interval and R8 latency
        arm_pulse("R2");
        sb_q.push_back('{1'b1, 1'b0, W'(40 / 16), "R1 L=40"});
        repeat (3) @(negedge clk);
        gate_n_i = 1'b0;
        repeat (40) @(negedge clk);
        gate_n_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 done not yet after two edges", 32'(done_o), 0);
        @(negedge clk);
        chk("R8 done on third edge", 32'(done_o), 1);
        // R5 hold
        repeat (20) @(negedge clk);
        chk("R5 done held", 32'(done_o), 1);
        chk("R5 count held", 32'(count_o), 2);

        // R3 quantum boundary
        arm_pulse("R2 from done");
        measure(15, -1, "R3 L=15");
        arm_pulse("R2");
        measure(16, -1, "R3 L=16");
        arm_pulse("R2");
        measure(1, -1, "R8 one-cycle gate");

        // R4 lane carry (count 9 crosses lane 0)
        arm_pulse("R2");
        measure(16 * 9 + 3, -1, "R4 lane carry");

        // R7 arm during counting ignored
        arm_pulse("R2");
        measure(100, 50, "R7 arm while counting");

        // R7 rise while waiting ignored
        gate_n_i = 1'b0;
        repeat (5) @(negedge clk);
        arm_pulse("R2 gate low");
        gate_n_i = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7 rise in wait gives no done", 32'(done_o), 0);
        chk("R7 rise in wait gives no err", 32'(err_o), 0);
        measure(50, -1, "R7 after ignored rise");

        // R6 overflow boundary
        arm_pulse("R2");
        measure(FULL - 1, -1, "R6 max count");
        arm_pulse("R2");
        measure(FULL, -1, "R6 exact overflow");
        arm_pulse("R2 from error");
        measure(FULL + 700, -1, "R6 long overflow");
        repeat (10) @(negedge clk);
        chk("R6 err held after rise", 32'(err_o), 1);
        chk("R6 no done", 32'(done_o), 0);
        chk("R6 count zero", 32'(count_o), 0);
        arm_pulse("R2 after overflow");

        chk("scoreboard drained", 32'(sb_q.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule